// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block sits between an in-order decode stage and a set of execution units. Decode writes up to two instructions per cycle into a small pool of slots. Each slot holds the execution class the instruction needs, a destination tag, and two source tags, each with its own ready bit. Decode keeps writing for as long as slots are free. An instruction that waits on a result therefore does not hold up younger instructions behind it. An instruction leaves the window as soon as both its sources are ready and the execution unit for its class is free. Program order is ignored when choosing which instruction issues, so a younger independent instruction can go ahead of an older dependent one.

Result broadcasts carry a destination tag. Every waiting source with that tag is marked ready. Each class has its own issue port:
- class 0: integer
- class 1: floating-point
- class 2: memory

Within a class, the oldest eligible instruction wins. A flush input empties the window in one cycle. Register renaming, execution and retirement are handled elsewhere.

The decode side is a two-lane valid/ready interface:
- A lane transfers in a cycle where its valid and ready are both high.
- Ready depends only on the window's occupancy at the start of the cycle and on flush. It never depends on valid.
- A stalled lane must hold its payload until the transfer happens.
- Lane 0 is older than lane 1 when both transfer in the same cycle.

The issue ports and the broadcast inputs are plain strobes with no handshake. The unit-free inputs tell the window which classes may issue this cycle.

Top module: `ooo_issue_window`

## Requirements
- R1: Lane 0 ready is high when at least one slot is free, and lane 1 ready is high when at least two slots are free. Occupancy is counted at the start of the cycle, so issues in the same cycle do not add space. Both ready signals are low while flush is high. An instruction accepted on lane 0 is older than one accepted on lane 1 in the same cycle.
- R2: `win_full` is high exactly when every slot holds an instruction. It stays high until an instruction issues or a flush occurs.
- R3: An instruction is eligible only when it is in the window, both of its source ready bits are set, and `fu_free` is high for its class. No issue port fires while its `fu_free` bit is low.
- R4: On each class port, the oldest eligible instruction of that class issues, whatever older instructions of other classes or with unready sources are waiting.
- R5: The class encoding is integer = 0, floating-point = 1, memory = 2. Class c issues on bit c of `iss_valid` and on field c (bits c*TAG_W upward) of `iss_dst`, `iss_src0` and `iss_src1`. Each field carries the instruction's stored tags.
- R6: A broadcast tag sets every matching source ready bit at the end of the cycle it is seen. This includes sources of instructions being written in that same cycle. Such an instruction can issue in the following cycle.
- R7: An issued instruction issues exactly once. Its slot becomes free for writes from the next cycle on.
- R8: While flush is high, nothing issues and nothing is accepted. From the next cycle on the window is empty.
- R9: After reset the window is empty: no issue is valid, both ready signals are high, and `win_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the window |
| dec_valid | input | 2 | Per-lane write request from decode |
| dec_ready | output | 2 | Per-lane acceptance |
| dec_cls | input | 4 | Class per lane, 2 bits each |
| dec_dst | input | 2*TAG_W | Destination tag per lane |
| dec_src0 | input | 2*TAG_W | First source tag per lane |
| dec_src1 | input | 2*TAG_W | Second source tag per lane |
| dec_rdy0 | input | 2 | First source already available, per lane |
| dec_rdy1 | input | 2 | Second source already available, per lane |
| wb_valid | input | NUM_WB | Result broadcast strobes |
| wb_tag | input | NUM_WB*TAG_W | Broadcast tags |
| fu_free | input | 3 | Execution unit of each class can take an instruction |
| iss_valid | output | 3 | Issue strobe per class |
| iss_dst | output | 3*TAG_W | Issued destination tag per class |
| iss_src0 | output | 3*TAG_W | Issued first source tag per class |
| iss_src1 | output | 3*TAG_W | Issued second source tag per class |
| win_full | output | 1 | No free slot; decode must stall |

## Verification
The bench replays a four-instruction sequence in which the last instruction is independent and must issue before the third, which waits on a chain of results. A window that kept program order would issue them in sequence and miss that ordering.

Several corner cases are targeted directly:
- **Wake-up on write:** an instruction is written in the same cycle its source tag is broadcast. A design that missed the match would leave it stuck forever.
- **Freed space and lane 1:** the window is filled, then one instruction is released. A design that counted same-cycle frees would offer lane 1 a slot it cannot hold, overwriting a live entry. A design that never reused slots would stay full.
- **Oldest first with a stalled unit:** two memory instructions wait while their unit is busy. A picker that used slot position instead of age would release them in the wrong order once the unit frees.

A long random phase mixes flushes, stalled units and competing broadcasts against a queue-based reference model.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int NUM_CLS = 3;
  localparam int LANES   = 2;
  localparam int CLS_W   = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_MEM = 2'd2
  } fu_cls_e;
endpackage

// File: rtl/iw_slot_find.sv
// Picks the two lowest-numbered free slots.
module iw_slot_find #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic [IDX_W-1:0] slot_a,
  output logic [IDX_W-1:0] slot_b
);
  always_comb begin
    logic got_a;
    logic got_b;
    got_a  = 1'b0;
    got_b  = 1'b0;
    slot_a = '0;
    slot_b = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!busy[i]) begin
        if (!got_a) begin
          slot_a = IDX_W'(i);
          got_a  = 1'b1;
        end else if (!got_b) begin
          slot_b = IDX_W'(i);
          got_b  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iw_oldest_pick.sv
// One-hot grant to the candidate with the smallest age rank.
module iw_oldest_pick #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 3
) (
  input  logic [DEPTH-1:0]        cand,
  input  logic [DEPTH*RANK_W-1:0] rank_flat,
  output logic [DEPTH-1:0]        grant
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      grant[i] = cand[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && cand[j] &&
            rank_flat[j*RANK_W +: RANK_W] < rank_flat[i*RANK_W +: RANK_W])
          grant[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ooo_issue_window.sv
module ooo_issue_window
  import iw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int NUM_WB = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [LANES-1:0]           dec_valid,
  output logic [LANES-1:0]           dec_ready,
  input  logic [LANES*CLS_W-1:0]     dec_cls,
  input  logic [LANES*TAG_W-1:0]     dec_dst,
  input  logic [LANES*TAG_W-1:0]     dec_src0,
  input  logic [LANES*TAG_W-1:0]     dec_src1,
  input  logic [LANES-1:0]           dec_rdy0,
  input  logic [LANES-1:0]           dec_rdy1,
  input  logic [NUM_WB-1:0]          wb_valid,
  input  logic [NUM_WB*TAG_W-1:0]    wb_tag,
  input  logic [NUM_CLS-1:0]         fu_free,
  output logic [NUM_CLS-1:0]         iss_valid,
  output logic [NUM_CLS*TAG_W-1:0]   iss_dst,
  output logic [NUM_CLS*TAG_W-1:0]   iss_src0,
  output logic [NUM_CLS*TAG_W-1:0]   iss_src1,
  output logic                       win_full
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int RANK_W = IDX_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [TAG_W-1:0]  dst;
    logic [TAG_W-1:0]  s0;
    logic [TAG_W-1:0]  s1;
    logic              r0;
    logic              r1;
    logic [RANK_W-1:0] rank;
  } slot_t;

  function automatic logic tag_hit(input logic [NUM_WB-1:0] v,
                                   input logic [NUM_WB*TAG_W-1:0] tags,
                                   input logic [TAG_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NUM_WB; k++)
      if (v[k] && tags[k*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  slot_t                         slot_q [DEPTH];
  slot_t                         slot_d [DEPTH];
  logic [DEPTH-1:0]              live_q;
  logic [CNT_W-1:0]              occ;
  logic [IDX_W-1:0]              free_a, free_b;
  logic [LANES-1:0]              take;
  logic [DEPTH*RANK_W-1:0]       rank_flat;
  logic [NUM_CLS-1:0][DEPTH-1:0] grant;
  logic [DEPTH-1:0]              leaving;
  logic [CNT_W-1:0]              n_leave;
  logic [RANK_W-1:0]             base_rank;

  assign occ      = CNT_W'($countones(live_q));
  assign n_leave  = CNT_W'($countones(leaving));
  assign win_full = (occ == CNT_W'(DEPTH));

  assign dec_ready[0] = !flush && (occ < CNT_W'(DEPTH));
  assign dec_ready[1] = !flush && (occ <= CNT_W'(DEPTH - 2));
  assign take         = dec_valid & dec_ready;
  assign base_rank    = RANK_W'(occ - n_leave);

  iw_slot_find #(.DEPTH(DEPTH)) u_find (
    .busy  (live_q),
    .slot_a(free_a),
    .slot_b(free_b)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rank_flat[i*RANK_W +: RANK_W] = slot_q[i].rank;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [DEPTH-1:0] cand;
    always_comb begin
      for (int i = 0; i < DEPTH; i++)
        cand[i] = live_q[i] && slot_q[i].r0 && slot_q[i].r1 &&
                  (slot_q[i].cls == CLS_W'(c)) && fu_free[c] && !flush;
    end
    iw_oldest_pick #(.DEPTH(DEPTH), .RANK_W(RANK_W)) u_pick (
      .cand     (cand),
      .rank_flat(rank_flat),
      .grant    (grant[c])
    );
  end

  always_comb begin
    leaving   = '0;
    iss_valid = '0;
    iss_dst   = '0;
    iss_src0  = '0;
    iss_src1  = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      iss_valid[c] = |grant[c];
      leaving      = leaving | grant[c];
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[c][i]) begin
          iss_dst [c*TAG_W +: TAG_W] = slot_q[i].dst;
          iss_src0[c*TAG_W +: TAG_W] = slot_q[i].s0;
          iss_src1[c*TAG_W +: TAG_W] = slot_q[i].s1;
        end
      end
    end
  end

  // Wake-up, age renumbering after departures, and writes of new entries.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int older_gone;
      older_gone = 0;
      for (int j = 0; j < DEPTH; j++)
        if (leaving[j] && slot_q[j].rank < slot_q[i].rank) older_gone++;
      slot_d[i]      = slot_q[i];
      slot_d[i].r0   = slot_q[i].r0 | tag_hit(wb_valid, wb_tag, slot_q[i].s0);
      slot_d[i].r1   = slot_q[i].r1 | tag_hit(wb_valid, wb_tag, slot_q[i].s1);
      slot_d[i].rank = slot_q[i].rank - RANK_W'(older_gone);
    end
    if (take[0]) begin
      slot_d[free_a].cls  = dec_cls[CLS_W-1:0];
      slot_d[free_a].dst  = dec_dst[TAG_W-1:0];
      slot_d[free_a].s0   = dec_src0[TAG_W-1:0];
      slot_d[free_a].s1   = dec_src1[TAG_W-1:0];
      slot_d[free_a].r0   = dec_rdy0[0] | tag_hit(wb_valid, wb_tag, dec_src0[TAG_W-1:0]);
      slot_d[free_a].r1   = dec_rdy1[0] | tag_hit(wb_valid, wb_tag, dec_src1[TAG_W-1:0]);
      slot_d[free_a].rank = base_rank;
    end
    if (take[1]) begin
      slot_d[free_b].cls  = dec_cls[CLS_W +: CLS_W];
      slot_d[free_b].dst  = dec_dst[TAG_W +: TAG_W];
      slot_d[free_b].s0   = dec_src0[TAG_W +: TAG_W];
      slot_d[free_b].s1   = dec_src1[TAG_W +: TAG_W];
      slot_d[free_b].r0   = dec_rdy0[1] | tag_hit(wb_valid, wb_tag, dec_src0[TAG_W +: TAG_W]);
      slot_d[free_b].r1   = dec_rdy1[1] | tag_hit(wb_valid, wb_tag, dec_src1[TAG_W +: TAG_W]);
      slot_d[free_b].rank = base_rank + RANK_W'(take[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      live_q <= '0;
    end else begin
      live_q <= (live_q & ~leaving)
              | (take[0] ? (DEPTH'(1) << free_a) : '0)
              | (take[1] ? (DEPTH'(1) << free_b) : '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
  end
endmodule

// File: rtl/iw_checker.sv
module iw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic [1:0] dec_ready,
  input logic [2:0] fu_free,
  input logic [2:0] iss_valid,
  input logic       win_full
);
  AST_LANE1_NEEDS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ready[1] |-> dec_ready[0]); // R1
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |-> (dec_ready == 2'b00)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full && iss_valid == 3'b000 && !flush) |=> win_full); // R2
  AST_BUSY_UNIT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & ~fu_free) == 3'b000); // R3
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_valid == 3'b000 && dec_ready == 2'b00)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!win_full && iss_valid == 3'b000)); // R8
endmodule

bind ooo_issue_window iw_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .dec_ready(dec_ready),
  .fu_free  (fu_free),
  .iss_valid(iss_valid),
  .win_full (win_full)
);

// File: tb/ooo_issue_window_tb.sv
module ooo_issue_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;
  localparam int NWB   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [1:0] dec_valid = '0;
  logic [1:0] dec_ready;
  logic [3:0] dec_cls = '0;
  logic [2*TAG_W-1:0] dec_dst = '0, dec_src0 = '0, dec_src1 = '0;
  logic [1:0] dec_rdy0 = '0, dec_rdy1 = '0;
  logic [NWB-1:0] wb_valid = '0;
  logic [NWB*TAG_W-1:0] wb_tag = '0;
  logic [2:0] fu_free = 3'b111;
  logic [2:0] iss_valid;
  logic [3*TAG_W-1:0] iss_dst, iss_src0, iss_src1;
  logic win_full;

  always #(CLK_PERIOD/2) clk = ~clk;

  ooo_issue_window #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NUM_WB(NWB)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_cls(dec_cls),
    .dec_dst(dec_dst), .dec_src0(dec_src0), .dec_src1(dec_src1),
    .dec_rdy0(dec_rdy0), .dec_rdy1(dec_rdy1),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .fu_free(fu_free),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src0(iss_src0),
    .iss_src1(iss_src1), .win_full(win_full)
  );

  typedef struct {int cls; int dst; int s0; int s1; bit r0; bit r1;} mdl_t;
  mdl_t q[$];
  int total = 0, bad = 0, cyc = 0;
  int issue_cyc[64];
  int issue_cnt[64];

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit hit(int t);
    for (int k = 0; k < NWB; k++)
      if (wb_valid[k] && int'(wb_tag[k*TAG_W +: TAG_W]) == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic lane(int l, int cls, int dst, int s0, bit r0, int s1, bit r1);
    dec_valid[l] = 1'b1;
    dec_cls[l*2 +: 2] = 2'(cls);
    dec_dst[l*TAG_W +: TAG_W] = TAG_W'(dst);
    dec_src0[l*TAG_W +: TAG_W] = TAG_W'(s0);
    dec_src1[l*TAG_W +: TAG_W] = TAG_W'(s1);
    dec_rdy0[l] = r0;
    dec_rdy1[l] = r1;
  endtask

  task automatic idle();
    dec_valid = '0; wb_valid = '0; flush = 1'b0;
  endtask

  task automatic bcast(int t);
    wb_valid[0] = 1'b1; wb_tag[TAG_W-1:0] = TAG_W'(t);
  endtask

  // Compare one cycle against the reference queue, then advance the queue.
  task automatic tick();
    int free;
    logic [1:0] exp_rdy;
    logic [2:0] exp_iv;
    int pick[3];
    mdl_t nq[$];
    #1;
    free = DEPTH - q.size();
    exp_rdy = flush ? 2'b00 : {free >= 2, free >= 1};
    check(dec_ready == exp_rdy, "R1", "dec_ready", dec_ready, exp_rdy);
    check(win_full == (free == 0), "R2", "win_full", win_full, free == 0);
    exp_iv = '0;
    for (int c = 0; c < 3; c++) begin
      pick[c] = -1;
      if (!flush && fu_free[c])
        for (int i = 0; i < q.size(); i++)
          if (pick[c] < 0 && q[i].cls == c && q[i].r0 && q[i].r1) pick[c] = i;
      exp_iv[c] = (pick[c] >= 0);
    end
    check(iss_valid == exp_iv, "R4", "iss_valid", iss_valid, exp_iv);
    for (int c = 0; c < 3; c++) begin
      if (exp_iv[c] && iss_valid[c]) begin
        check(int'(iss_dst[c*TAG_W +: TAG_W]) == q[pick[c]].dst, "R5", "iss_dst",
              iss_dst[c*TAG_W +: TAG_W], q[pick[c]].dst);
        check(int'(iss_src0[c*TAG_W +: TAG_W]) == q[pick[c]].s0 &&
              int'(iss_src1[c*TAG_W +: TAG_W]) == q[pick[c]].s1, "R5", "iss_src",
              {iss_src0[c*TAG_W +: TAG_W], iss_src1[c*TAG_W +: TAG_W]},
              q[pick[c]].s0 * 64 + q[pick[c]].s1);
        issue_cyc[q[pick[c]].dst] = cyc;
        issue_cnt[q[pick[c]].dst]++;
      end
    end
    if (!flush) begin
      for (int i = 0; i < q.size(); i++) begin
        mdl_t e;
        if (i == pick[0] || i == pick[1] || i == pick[2]) continue;
        e = q[i];
        e.r0 = e.r0 | hit(e.s0);
        e.r1 = e.r1 | hit(e.s1);
        nq.push_back(e);
      end
      for (int l = 0; l < 2; l++) begin
        if (dec_valid[l] && exp_rdy[l]) begin
          mdl_t e;
          e.cls = int'(dec_cls[l*2 +: 2]);
          e.dst = int'(dec_dst[l*TAG_W +: TAG_W]);
          e.s0  = int'(dec_src0[l*TAG_W +: TAG_W]);
          e.s1  = int'(dec_src1[l*TAG_W +: TAG_W]);
          e.r0  = dec_rdy0[l] | hit(e.s0);
          e.r1  = dec_rdy1[l] | hit(e.s1);
          nq.push_back(e);
        end
      end
    end
    q = nq;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bc10;
    for (int i = 0; i < 64; i++) begin issue_cyc[i] = -1; issue_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: empty after reset
    check(dec_ready == 2'b11, "R9", "dec_ready after reset", dec_ready, 3);
    check(iss_valid == 3'b000, "R9", "iss_valid after reset", iss_valid, 0);
    check(win_full == 1'b0, "R9", "win_full after reset", win_full, 0);

    // Four-instruction sequence: I4 (independent) must issue before I3.
    idle(); lane(0, 0, 10, 1, 1, 2, 1); lane(1, 0, 11, 10, 0, 2, 1); tick();
    idle(); lane(0, 1, 12, 11, 0, 2, 1); lane(1, 1, 13, 3, 1, 4, 1); tick();
    idle(); tick();
    idle(); bcast(10); bc10 = cyc; tick();
    idle(); tick();
    idle(); bcast(11); tick();
    repeat (3) begin idle(); tick(); end
    check(issue_cyc[13] >= 0 && issue_cyc[13] < issue_cyc[12], "R4", "I4 issue before I3",
          issue_cyc[13], issue_cyc[12]);
    check(issue_cyc[11] == bc10 + 1, "R6", "wake-up cycle of I2", issue_cyc[11], bc10 + 1);

    // R6: written in the same cycle its source is broadcast
    idle(); lane(0, 0, 14, 20, 0, 2, 1); bcast(20); tick();
    idle(); tick();
    check(issue_cnt[14] == 1, "R6", "same-cycle wake on write", issue_cnt[14], 1);

    // R3/R4: memory unit busy, then the older of two goes first
    fu_free = 3'b011;
    idle(); lane(0, 2, 21, 1, 1, 1, 1); lane(1, 2, 22, 1, 1, 1, 1); tick();
    repeat (3) begin idle(); tick(); end
    check(issue_cnt[21] == 0 && issue_cnt[22] == 0, "R3", "no issue while unit busy",
          issue_cnt[21] + issue_cnt[22], 0);
    fu_free = 3'b111;
    repeat (3) begin idle(); tick(); end
    check(issue_cyc[21] >= 0 && issue_cyc[21] < issue_cyc[22], "R4", "older memory op first",
          issue_cyc[21], issue_cyc[22]);
    for (int t = 10; t <= 14; t++)
      check(issue_cnt[t] == 1, "R7", "issued exactly once", issue_cnt[t], 1);

    // Fill the window, then release one slot.
    for (int k = 0; k < 4; k++) begin
      idle(); lane(0, 0, 30 + 2*k, 40 + 2*k, 0, 1, 1); lane(1, 0, 31 + 2*k, 41 + 2*k, 0, 1, 1); tick();
    end
    idle(); lane(0, 0, 50, 1, 1, 1, 1); lane(1, 0, 51, 1, 1, 1, 1); #1;
    check(win_full == 1'b1, "R2", "full after eight writes", win_full, 1);
    check(dec_ready == 2'b00, "R2", "writes refused when full", dec_ready, 0);
    tick();
    idle(); bcast(40); tick();
    idle(); tick();
    check(dec_ready == 2'b01, "R7", "one freed slot offered to lane 0 only", dec_ready, 1);
    check(issue_cnt[50] == 0, "R2", "refused write never issues", issue_cnt[50], 0);

    // R8: flush
    idle(); flush = 1'b1; tick();
    idle(); #1;
    check(dec_ready == 2'b11 && win_full == 1'b0, "R8", "empty after flush",
          {dec_ready, win_full}, 6);
    idle(); bcast(41); tick();
    idle(); tick();
    check(issue_cnt[31] == 0, "R8", "flushed entry never issues", issue_cnt[31], 0);

    // Random mixed traffic against the reference queue.
    for (int n = 0; n < 3000; n++) begin
      idle();
      flush = ($urandom % 64) == 0;
      for (int l = 0; l < 2; l++)
        if ($urandom % 3 != 0)
          lane(l, $urandom % 3, $urandom % 16, $urandom % 16, 1'($urandom % 2),
               $urandom % 16, 1'($urandom % 2));
      for (int k = 0; k < NWB; k++) begin
        wb_valid[k] = 1'($urandom % 2);
        wb_tag[k*TAG_W +: TAG_W] = TAG_W'($urandom % 16);
      end
      fu_free = 3'($urandom % 8) | 3'(($urandom % 2) ? 7 : 0);
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule